// File: doc/BRIEF.md
# Paravirtual Device Interrupt Status Unit

This unit raises the interrupts of a paravirtual I/O device attached over PCI. Two single-cycle event strobes come in. One marks a used-buffer event on a selected queue. The other marks a change of the device configuration. The unit records events in an 8-bit status register. The driver reads that register through a plain read strobe, and the read also empties it. While MSI-X is off, the unit drives a level-sensitive legacy INTx line. While MSI-X is on, it issues message requests. Each request carries a table entry number, taken from a programmable vector register for each queue and one for the configuration.

A configuration change always marks its status bit, whatever the MSI-X setting. A queue event marks its bit only while MSI-X is off. With MSI-X on, a queue event instead queues a message request through that queue's vector register. Events whose vector is the all-ones no-vector value produce no message.

Two small state machines do the work. The status machine has states CLEAR and FLAGGED. It moves CLEAR to FLAGGED when an event marks a bit. It moves FLAGGED to CLEAR on a read that comes with no new event. It stays in FLAGGED when an event arrives in the same cycle as a read. The message machine has states IDLE and SEND. It moves IDLE to SEND when a pending source has a usable vector. It moves SEND to IDLE when the request is accepted. In IDLE it drops a pending source whose vector has since become the no-vector value.

Top module: `pvirq_unit`

## Requirements
- R1: After reset the status reads 0, `intx` and `msg_valid` are low, and every vector register holds the no-vector value 16'hFFFF. Until a vector is programmed, no event produces a message.
- R2: `stat_rdata` always shows the current status. On a cycle with `stat_rd` high and no event, the status is 0 from the next cycle on.
- R3: A `cfg_evt` sets status bit 1 at the next clock edge, with MSI-X on or off.
- R4: With `msix_en` low, a `queue_evt` sets status bit 0 at the next edge. With `msix_en` high, a `queue_evt` leaves the status unchanged.
- R5: Status bits 7 down to 2 always read 0.
- R6: `intx` is high exactly when the status is nonzero and `msix_en` is low. It therefore falls in the cycle after a clearing read.
- R7: With `msix_en` high, a `cfg_evt` requests a message with the configuration vector (vector address 4), unless that vector is 16'hFFFF.
- R8: With `msix_en` high, a `queue_evt` on queue n requests a message with vector register n (addresses 0 to 3), unless that vector is 16'hFFFF. A source whose vector reads 16'hFFFF at issue time is dropped.
- R9: An event in the same cycle as a read makes the read return the old value. The event's bit is set once the clear has taken effect.
- R10: `msg_valid` and `msg_vector` hold steady until `msg_ready` is seen high. `msg_valid` then falls in the next cycle. With `msg_ready` high, `msg_valid` lasts one cycle.
- R11: Pending requests issue with the configuration first, then queues in ascending order. A repeated event from a source that is still pending merges into a single message.
- R12: From IDLE, `msg_valid` rises in the second cycle after the edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msix_en | input | 1 | MSI-X enabled |
| queue_evt | input | 1 | Queue used-buffer event strobe |
| queue_sel | input | 2 | Queue index for `queue_evt` |
| cfg_evt | input | 1 | Configuration-change event strobe |
| stat_rd | input | 1 | Status read strobe (clears on read) |
| stat_rdata | output | 8 | Status value, bit 0 queue, bit 1 configuration |
| intx | output | 1 | Legacy level interrupt |
| vec_we | input | 1 | Vector register write strobe |
| vec_waddr | input | 3 | Vector address: 0..3 queues, 4 configuration |
| vec_wdata | input | 16 | Vector write data |
| msg_valid | output | 1 | Message request valid |
| msg_vector | output | 16 | Table entry number of the request |
| msg_ready | input | 1 | Message request accepted |

## Verification
A wrong status state shows at `stat_rdata` and `intx` one cycle after the edge that caused it. Examples are a lost bit when an event collides with a read, a bit that survives a read, or a queue bit set while MSI-X is on. A wrong pending set or a wrong message state shows as a missing, duplicated or misordered request, or as a vector that changes while the request waits. A reference model compares every output on every cycle, so such faults appear within two cycles of the event. Checks on the log of accepted messages catch ordering and merging faults that only show once the queue drains.

// File: rtl/pvirq_pkg.sv
package pvirq_pkg;
    localparam int STAT_W   = 8;
    localparam int QBIT_POS = 0;
    localparam int CBIT_POS = 1;

    typedef enum logic {
        ST_CLEAR,
        ST_FLAGGED
    } stat_state_e;

    typedef enum logic {
        MX_IDLE,
        MX_SEND
    } mx_state_e;
endpackage

// File: rtl/pvirq_vecfile.sv
module pvirq_vecfile #(
    parameter int NUM_VEC = 5,
    parameter int VEC_W   = 16,
    parameter int AW      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [VEC_W-1:0] wdata,
    output logic [VEC_W-1:0] vec_o [NUM_VEC]
);
    localparam logic [VEC_W-1:0] NO_VEC = {VEC_W{1'b1}};

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_ent
        logic [VEC_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= NO_VEC;
            end else if (we && (waddr == AW'(i))) begin
                ent_q <= wdata;
            end
        end
        assign vec_o[i] = ent_q;
    end
endmodule

// File: rtl/pvirq_status.sv
module pvirq_status
    import pvirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msix_en,
    input  logic              queue_hit,
    input  logic              cfg_evt,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_o,
    output logic              intx
);
    stat_state_e state_q, state_n;
    logic [1:0]  flags_q, flags_n;

    // next state and next flags
    always_comb begin
        flags_n = stat_rd ? 2'b00 : flags_q;
        if (cfg_evt) begin
            flags_n[CBIT_POS] = 1'b1;
        end
        if (queue_hit && !msix_en) begin
            flags_n[QBIT_POS] = 1'b1;
        end
        state_n = state_q;
        unique case (state_q)
            ST_CLEAR:   if (flags_n != 2'b00) state_n = ST_FLAGGED;
            ST_FLAGGED: if (flags_n == 2'b00) state_n = ST_CLEAR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            flags_q <= 2'b00;
        end else begin
            state_q <= state_n;
            flags_q <= flags_n;
        end
    end

    // outputs
    always_comb begin
        stat_o = {{(STAT_W-2){1'b0}}, flags_q};
        intx   = 1'b0;
        unique case (state_q)
            ST_CLEAR:   intx = 1'b0;
            ST_FLAGGED: intx = !msix_en;
        endcase
    end
endmodule

// File: rtl/pvirq_msix.sv
module pvirq_msix
    import pvirq_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    parameter int VEC_W      = 16,
    parameter int QSW        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msix_en,
    input  logic             queue_hit,
    input  logic [QSW-1:0]   queue_sel,
    input  logic             cfg_evt,
    input  logic [VEC_W-1:0] vec_i [NUM_QUEUES+1],
    input  logic             msg_ready,
    output logic             msg_valid,
    output logic [VEC_W-1:0] msg_vector
);
    localparam int NSRC    = NUM_QUEUES + 1;
    localparam int CFG_IDX = NUM_QUEUES;
    localparam int PW      = $clog2(NSRC);
    localparam logic [VEC_W-1:0] NO_VEC = {VEC_W{1'b1}};

    mx_state_e        state_q, state_n;
    logic [NSRC-1:0]  pend_q, pend_n, ev_set, clr;
    logic [PW-1:0]    pick;
    logic             found;
    logic [VEC_W-1:0] vec_q, vec_n;

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_qset
        assign ev_set[q] = msix_en && queue_hit && (queue_sel == QSW'(q))
                           && (vec_i[q] != NO_VEC);
    end
    assign ev_set[CFG_IDX] = msix_en && cfg_evt && (vec_i[CFG_IDX] != NO_VEC);

    // priority pick: configuration first, then lowest queue
    always_comb begin
        pick  = PW'(CFG_IDX);
        found = |pend_q;
        if (!pend_q[CFG_IDX]) begin
            for (int i = NUM_QUEUES - 1; i >= 0; i--) begin
                if (pend_q[i]) pick = PW'(i);
            end
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        clr     = '0;
        vec_n   = vec_q;
        unique case (state_q)
            MX_IDLE: begin
                if (found) begin
                    clr[pick] = 1'b1;
                    if (vec_i[pick] != NO_VEC) begin
                        vec_n   = vec_i[pick];
                        state_n = MX_SEND;
                    end
                end
            end
            MX_SEND: begin
                if (msg_ready) state_n = MX_IDLE;
            end
        endcase
        pend_n = (pend_q & ~clr) | ev_set;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MX_IDLE;
            pend_q  <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_n;
            pend_q  <= pend_n;
            vec_q   <= vec_n;
        end
    end

    // outputs
    always_comb begin
        msg_valid  = 1'b0;
        msg_vector = vec_q;
        unique case (state_q)
            MX_IDLE: msg_valid = 1'b0;
            MX_SEND: msg_valid = 1'b1;
        endcase
    end
endmodule

// File: rtl/pvirq_unit.sv
module pvirq_unit
    import pvirq_pkg::*;
#(
    parameter int NUM_QUEUES = 4,
    parameter int VEC_W      = 16,
    localparam int QSW       = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
    localparam int VAW       = $clog2(NUM_QUEUES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msix_en,
    input  logic              queue_evt,
    input  logic [QSW-1:0]    queue_sel,
    input  logic              cfg_evt,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              intx,
    input  logic              vec_we,
    input  logic [VAW-1:0]    vec_waddr,
    input  logic [VEC_W-1:0]  vec_wdata,
    output logic              msg_valid,
    output logic [VEC_W-1:0]  msg_vector,
    input  logic              msg_ready
);
    logic [VEC_W-1:0] vec_tab [NUM_QUEUES+1];
    logic             queue_hit;

    assign queue_hit = queue_evt && (int'(queue_sel) < NUM_QUEUES);

    pvirq_vecfile #(
        .NUM_VEC(NUM_QUEUES + 1),
        .VEC_W  (VEC_W),
        .AW     (VAW)
    ) u_vec (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (vec_we),
        .waddr(vec_waddr),
        .wdata(vec_wdata),
        .vec_o(vec_tab)
    );

    pvirq_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .msix_en  (msix_en),
        .queue_hit(queue_hit),
        .cfg_evt  (cfg_evt),
        .stat_rd  (stat_rd),
        .stat_o   (stat_rdata),
        .intx     (intx)
    );

    pvirq_msix #(
        .NUM_QUEUES(NUM_QUEUES),
        .VEC_W     (VEC_W),
        .QSW       (QSW)
    ) u_msix (
        .clk       (clk),
        .rst_n     (rst_n),
        .msix_en   (msix_en),
        .queue_hit (queue_hit),
        .queue_sel (queue_sel),
        .cfg_evt   (cfg_evt),
        .vec_i     (vec_tab),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_vector(msg_vector)
    );
endmodule

// File: rtl/pvirq_unit_chk.sv
module pvirq_unit_chk #(
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msix_en,
    input logic             queue_evt,
    input logic             cfg_evt,
    input logic             stat_rd,
    input logic [7:0]       stat_rdata,
    input logic             intx,
    input logic             msg_valid,
    input logic [VEC_W-1:0] msg_vector,
    input logic             msg_ready
);
    // R5
    stat_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[7:2] == 6'd0);

    // R6
    intx_msix_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msix_en |-> !intx);

    // R2
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !cfg_evt && !queue_evt) |=> (stat_rdata == 8'd0));

    // R3
    cfg_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_evt |=> stat_rdata[1]);

    // R4
    queue_msix_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msix_en && queue_evt && !stat_rd && !cfg_evt) |=> $stable(stat_rdata));

    // R10
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)));

    // R10
    msg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    // R8
    msg_no_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_vector != {VEC_W{1'b1}}));
endmodule

bind pvirq_unit pvirq_unit_chk #(.VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msix_en   (msix_en),
    .queue_evt (queue_evt),
    .cfg_evt   (cfg_evt),
    .stat_rd   (stat_rd),
    .stat_rdata(stat_rdata),
    .intx      (intx),
    .msg_valid (msg_valid),
    .msg_vector(msg_vector),
    .msg_ready (msg_ready)
);

// File: tb/pvirq_unit_test.sv
`timescale 1ns/1ps
module pvirq_unit_test;
    localparam int NQ = 4;
    localparam int NOV = 16'hFFFF;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        msix_en = 0, queue_evt = 0, cfg_evt = 0, stat_rd = 0;
    logic [1:0]  queue_sel = 0;
    logic [7:0]  stat_rdata;
    logic        intx, vec_we = 0, msg_valid, msg_ready = 0;
    logic [2:0]  vec_waddr = 0;
    logic [15:0] vec_wdata = 0, msg_vector;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pvirq_unit uut (.*);

    // ---------------- behavioural reference model ----------------
    int m_stat, m_busy, m_vec_out;
    int m_vec[NQ+1];
    bit m_pend[NQ+1];
    int acc_log[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 0; m_busy = 0; m_vec_out = 0;
            foreach (m_vec[i]) begin m_vec[i] = NOV; m_pend[i] = 0; end
        end else begin
            int ns;
            bit np[NQ+1];
            ns = stat_rd ? 0 : m_stat;
            if (cfg_evt) ns = ns | 2;
            if (queue_evt && !msix_en) ns = ns | 1;
            np = m_pend;
            if (m_busy != 0) begin
                if (msg_ready) m_busy = 0;
            end else begin
                int p;
                p = -1;
                if (m_pend[NQ]) p = NQ;
                else for (int i = 0; i < NQ; i++) if (p < 0 && m_pend[i]) p = i;
                if (p >= 0) begin
                    np[p] = 0;
                    if (m_vec[p] != NOV) begin m_busy = 1; m_vec_out = m_vec[p]; end
                end
            end
            if (msix_en && cfg_evt && m_vec[NQ] != NOV) np[NQ] = 1;
            if (msix_en && queue_evt && m_vec[queue_sel] != NOV) np[queue_sel] = 1;
            m_pend = np;
            m_stat = ns;
            if (vec_we && vec_waddr <= NQ) m_vec[vec_waddr] = vec_wdata;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act %0h exp %0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 model stat_rdata", stat_rdata, m_stat);
            chk("R6 model intx", intx, (m_stat != 0 && !msix_en) ? 1 : 0);
            chk("R10 model msg_valid", msg_valid, m_busy);
            if (msg_valid && m_busy != 0) chk("R10 model msg_vector", msg_vector, m_vec_out);
            if (msg_valid && msg_ready) acc_log.push_back(int'(msg_vector));
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(posedge clk); #1;
        queue_evt = 0; cfg_evt = 0; stat_rd = 0; vec_we = 0;
    endtask

    task automatic wr_vec(int a, int d);
        vec_we = 1; vec_waddr = 3'(a); vec_wdata = 16'(d);
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act running exp finished");
        finish_run();
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        chk("R1 stat after reset", stat_rdata, 0);
        chk("R1 intx after reset", intx, 0);
        chk("R1 msg_valid after reset", msg_valid, 0);

        // R4 queue event with MSI-X off
        queue_evt = 1; queue_sel = 2; cyc();
        chk("R4 queue bit set", stat_rdata, 8'h01);
        chk("R6 intx high", intx, 1);
        // R3 configuration event
        cfg_evt = 1; cyc();
        chk("R3 cfg bit set", stat_rdata, 8'h03);
        chk("R5 upper bits zero", int'(stat_rdata[7:2]), 0);
        // R2 read returns then clears
        stat_rd = 1;
        chk("R2 read value", stat_rdata, 8'h03);
        cyc();
        chk("R2 cleared after read", stat_rdata, 0);
        chk("R6 intx dropped after read", intx, 0);
        // R9 event colliding with read
        queue_evt = 1; cyc();
        cfg_evt = 1; stat_rd = 1;
        chk("R9 read returns old", stat_rdata, 8'h01);
        cyc();
        chk("R9 new bit survives clear", stat_rdata, 8'h02);
        stat_rd = 1; cyc();

        // R1/R7 MSI-X on, vectors still at no-vector
        msix_en = 1; msg_ready = 1;
        #0 chk("R6 intx low with MSI-X", intx, 0);
        cfg_evt = 1; cyc();
        chk("R3 cfg bit with MSI-X", stat_rdata, 8'h02);
        chk("R6 intx low with bit set", intx, 0);
        queue_evt = 1; queue_sel = 0; cyc();
        repeat (3) cyc();
        chk("R1 no message with unprogrammed vectors", acc_log.size(), 0);
        chk("R4 queue under MSI-X leaves status", stat_rdata, 8'h02);
        stat_rd = 1; cyc();

        // program vectors
        wr_vec(0, 5); wr_vec(1, 6); wr_vec(2, 7); wr_vec(3, 8); wr_vec(4, 'h20);
        acc_log.delete();

        // R8 / R12 queue message latency
        queue_evt = 1; queue_sel = 2; cyc();
        chk("R12 no valid one cycle after event", msg_valid, 0);
        cyc();
        chk("R12 valid two cycles after event", msg_valid, 1);
        chk("R8 queue vector", msg_vector, 7);
        cyc();
        chk("R10 single-cycle valid when ready", msg_valid, 0);
        chk("R8 one message logged", acc_log.size(), 1);
        chk("R4 status untouched by MSI-X queue event", stat_rdata, 0);
        acc_log.delete();

        // R7 / R10 / R11 backpressure, ordering, merging
        msg_ready = 0;
        cfg_evt = 1; queue_evt = 1; queue_sel = 1; cyc();
        queue_evt = 1; queue_sel = 0; cyc();
        chk("R7 cfg vector first", msg_vector, 'h20);
        queue_evt = 1; queue_sel = 1; cyc();
        cyc(); cyc();
        chk("R10 valid held", msg_valid, 1);
        chk("R10 vector held", msg_vector, 'h20);
        msg_ready = 1;
        repeat (10) cyc();
        chk("R11 merged count", acc_log.size(), 3);
        if (acc_log.size() == 3) begin
            chk("R11 order first cfg", acc_log[0], 'h20);
            chk("R11 order second q0", acc_log[1], 5);
            chk("R11 order third q1", acc_log[2], 6);
        end
        acc_log.delete();

        // R8 vector returned to no-vector
        wr_vec(3, NOV);
        queue_evt = 1; queue_sel = 3; cyc();
        repeat (4) cyc();
        chk("R8 no message for no-vector queue", acc_log.size(), 0);

        // R8 dropped at issue: pending while vector cleared
        msg_ready = 0;
        queue_evt = 1; queue_sel = 0; cyc();
        queue_evt = 1; queue_sel = 1; cyc();
        wr_vec(1, NOV);
        msg_ready = 1;
        repeat (6) cyc();
        chk("R8 only live vector issued", acc_log.size(), 1);
        if (acc_log.size() == 1) chk("R8 live vector value", acc_log[0], 5);

        repeat (2) cyc();
        finish_run();
    end
endmodule